// File: doc/BRIEF.md
# Keyed Watchdog Timer

This block is a watchdog for a processor subsystem. A 12-bit down-counter steps once for every `DIV` pulses of a slow-clock tick input. Software must reload the counter in time by writing a restart command that carries an 8-bit key. If the counter steps past zero, or if a restart arrives too early, a fault is raised. Depending on the configuration, the fault raises an interrupt, a processor reset, or a full-system reset.

The configuration register can be written only once after power-on reset. The watchdog runs with safe default settings until that write. A disable bit in the configuration stops the watchdog for good. Two hold bits let the count pause while the system sleeps or while a debugger has halted the core. A small register port gives access to the control, configuration and status words. Reading the status word acknowledges pending faults.

Top module: `keyed_wdog`

## Requirements
- R1: Out of reset the counter holds 4095 and counts. A step at count 0 is an underflow fault: the counter reloads with the configured value field, and status bit 0 is set. Without a reload, each step happens after exactly `DIV` slow ticks.
- R2: The configuration word sits at address 1 with this layout: [11:0] reload value, [23:12] delta limit, 24 interrupt enable, 25 reset enable, 26 processor-only, 27 disable, 28 idle hold, 29 debug hold. Its reset value reads back as 0x02FF_FFFF. The first write is taken and reloads the counter with the new value field. Every later write leaves the word unchanged.
- R3: While the disable bit is set, the counter and prescaler do not move. No fault is raised and restart commands are ignored. The bit cannot be cleared before the next reset.
- R4: A write to address 0 with 0xA5 in bits [31:24] and bit 0 set reloads the counter with the value field and clears the prescaler. If a step falls in the same cycle as this write, the restart wins and no underflow occurs.
- R5: A control write with any other key is ignored, and counting goes on undisturbed.
- R6: A valid restart made while the counter is above the delta field is an error fault and sets status bit 1. The reload still happens. A restart at a count equal to the delta field is not an error.
- R7: With reset enable set, each fault pulses `cpu_rst_o` for one cycle. `sys_rst_o` pulses along with it unless processor-only is set.
- R8: The status word sits at address 2: bit 0 underflow, bit 1 error, bits [27:16] current count. The flags are set by every fault. `irq_o` is high while interrupt enable is set and a flag is set. A status read clears the flags, but a fault in the same cycle as the read leaves its flag set.
- R9: With idle hold set, the count freezes while `idle_i` is high. With debug hold set, the count freezes while `dbg_halt_i` is high. Neither input has any effect when its hold bit is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| slow_tick_i | input | 1 | One-cycle pulse per slow-clock period |
| idle_i | input | 1 | System idle/sleep indication |
| dbg_halt_i | input | 1 | Debugger halt indication |
| bus_wr_i | input | 1 | Register write strobe |
| bus_rd_i | input | 1 | Register read strobe |
| bus_addr_i | input | 2 | Register address: 0 control, 1 configuration, 2 status |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for the addressed register |
| irq_o | output | 1 | Fault interrupt |
| cpu_rst_o | output | 1 | Processor reset pulse |
| sys_rst_o | output | 1 | Full-system reset pulse |

## Verification
Two pairs of events can land in the same clock cycle. In the first, a keyed restart arrives in the very cycle where the counter, already at zero, receives its final prescaler tick. In the second, a status read arrives in the very cycle where a new underflow occurs. The bench sets these up by driving the slow tick pulse by pulse, so that the prescaler sits one tick short of a step before the colliding access is issued with a tick. It then judges the outcome from the interrupt line and from later status reads: the restart must suppress the underflow, and the new flag must survive the clearing read.

// File: rtl/kwd_pkg.sv
package kwd_pkg;

    localparam int CNT_W = 12;
    localparam logic [7:0] RESTART_KEY = 8'hA5;

    typedef struct packed {
        logic             dbg_hold;
        logic             idle_hold;
        logic             disable_wd;
        logic             proc_only;
        logic             rst_en;
        logic             irq_en;
        logic [CNT_W-1:0] delta;
        logic [CNT_W-1:0] value;
    } mode_t;

    localparam int MODE_W = $bits(mode_t);

    localparam mode_t MODE_DEFAULT = '{
        dbg_hold:   1'b0,
        idle_hold:  1'b0,
        disable_wd: 1'b0,
        proc_only:  1'b0,
        rst_en:     1'b1,
        irq_en:     1'b0,
        delta:      '1,
        value:      '1
    };

    typedef enum logic [1:0] {
        A_CTRL = 2'd0,
        A_MODE = 2'd1,
        A_STAT = 2'd2
    } addr_e;

    function automatic logic restart_cmd(input logic [31:0] d);
        return (d[31:24] == RESTART_KEY) && d[0];
    endfunction

endpackage

// File: rtl/kwd_prescale.sv
module kwd_prescale #(
    parameter int DIV = 128
) (
    input  logic clk,
    input  logic rst,
    input  logic tick_i,
    input  logic run_i,
    input  logic clr_i,
    output logic step_o
);
    localparam int PW = (DIV > 2) ? $clog2(DIV) : 1;
    localparam logic [PW-1:0] LAST = PW'(DIV - 1);

    logic [PW-1:0] pcnt_q;
    logic          at_last;

    assign at_last = (pcnt_q == LAST);
    assign step_o  = run_i && tick_i && at_last && !clr_i;

    always_ff @(posedge clk) begin
        if (rst || clr_i) begin
            pcnt_q <= '0;
        end else if (run_i && tick_i) begin
            pcnt_q <= at_last ? '0 : pcnt_q + 1'b1;
        end
    end

    AST_FROZEN_PRESCALE: assert property (@(posedge clk) disable iff (rst)
        (!run_i && !clr_i) |=> $stable(pcnt_q)); // R9

endmodule

// File: rtl/kwd_count.sv
module kwd_count #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en_i,
    input  logic         step_i,
    input  logic         load_i,
    input  logic [W-1:0] load_val_i,
    output logic [W-1:0] cnt_o,
    output logic         underflow_o
);
    logic [W-1:0] cnt_q;

    assign cnt_o       = cnt_q;
    assign underflow_o = en_i && step_i && !load_i && (cnt_q == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '1;
        end else if (load_i || underflow_o) begin
            cnt_q <= load_val_i;
        end else if (en_i && step_i) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    AST_RELOAD_TAKES: assert property (@(posedge clk) disable iff (rst)
        load_i |=> (cnt_q == $past(load_val_i))); // R4

    AST_UNDERFLOW_RELOADS: assert property (@(posedge clk) disable iff (rst)
        underflow_o |=> (cnt_q == $past(load_val_i))); // R1

    AST_HALT_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (!en_i && !load_i) |=> $stable(cnt_q)); // R3

endmodule

// File: rtl/kwd_regs.sv
module kwd_regs
    import kwd_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_i,
    input  logic             rd_i,
    input  logic [1:0]       addr_i,
    input  logic [31:0]      wdata_i,
    input  logic [CNT_W-1:0] cnt_i,
    input  logic             underflow_i,
    input  logic             idle_i,
    input  logic             dbg_i,
    output logic [31:0]      rdata_o,
    output logic             en_o,
    output logic             run_o,
    output logic             load_o,
    output logic [CNT_W-1:0] load_val_o,
    output logic             irq_o,
    output logic             cpu_rst_o,
    output logic             sys_rst_o
);
    mode_t mode_q;
    logic  locked_q;
    logic  unf_q, err_q;
    logic  cpu_rst_q, sys_rst_q;

    logic  mode_wr, restart_ok, err_evt, fault, rd_clr;
    mode_t mode_new;

    assign mode_new   = mode_t'(wdata_i[MODE_W-1:0]);
    assign mode_wr    = wr_i && (addr_i == A_MODE) && !locked_q;
    assign restart_ok = wr_i && (addr_i == A_CTRL) && restart_cmd(wdata_i)
                        && !mode_q.disable_wd;
    assign err_evt    = restart_ok && (cnt_i > mode_q.delta);
    assign fault      = underflow_i || err_evt;
    assign rd_clr     = rd_i && (addr_i == A_STAT);

    assign en_o       = !mode_q.disable_wd;
    assign run_o      = en_o && !(mode_q.idle_hold && idle_i)
                             && !(mode_q.dbg_hold && dbg_i);
    assign load_o     = mode_wr || restart_ok;
    assign load_val_o = mode_wr ? mode_new.value : mode_q.value;

    assign irq_o      = mode_q.irq_en && (unf_q || err_q);
    assign cpu_rst_o  = cpu_rst_q;
    assign sys_rst_o  = sys_rst_q;

    always_comb begin
        case (addr_i)
            A_MODE:  rdata_o = {{(32-MODE_W){1'b0}}, mode_q};
            A_STAT:  rdata_o = {4'b0, cnt_i, 14'b0, err_q, unf_q};
            default: rdata_o = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q   <= MODE_DEFAULT;
            locked_q <= 1'b0;
        end else if (mode_wr) begin
            mode_q   <= mode_new;
            locked_q <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            unf_q     <= 1'b0;
            err_q     <= 1'b0;
            cpu_rst_q <= 1'b0;
            sys_rst_q <= 1'b0;
        end else begin
            unf_q     <= underflow_i || (unf_q && !rd_clr);
            err_q     <= err_evt || (err_q && !rd_clr);
            cpu_rst_q <= fault && mode_q.rst_en;
            sys_rst_q <= fault && mode_q.rst_en && !mode_q.proc_only;
        end
    end

    AST_MODE_LOCKED: assert property (@(posedge clk) disable iff (rst)
        locked_q |=> $stable(mode_q)); // R2

    AST_DISABLE_STICKY: assert property (@(posedge clk) disable iff (rst)
        mode_q.disable_wd |=> mode_q.disable_wd); // R3

    AST_NO_FAULT_DISABLED: assert property (@(posedge clk) disable iff (rst)
        mode_q.disable_wd |-> !underflow_i); // R3

    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (rd_clr && !underflow_i) |=> !unf_q); // R8

    AST_FAULT_SURVIVES_READ: assert property (@(posedge clk) disable iff (rst)
        underflow_i |=> unf_q); // R8

endmodule

// File: rtl/keyed_wdog.sv
module keyed_wdog
    import kwd_pkg::*;
#(
    parameter int DIV = 128
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        slow_tick_i,
    input  logic        idle_i,
    input  logic        dbg_halt_i,
    input  logic        bus_wr_i,
    input  logic        bus_rd_i,
    input  logic [1:0]  bus_addr_i,
    input  logic [31:0] bus_wdata_i,
    output logic [31:0] bus_rdata_o,
    output logic        irq_o,
    output logic        cpu_rst_o,
    output logic        sys_rst_o
);
    logic             en, run, load, step, underflow;
    logic [CNT_W-1:0] load_val, cnt;

    kwd_prescale #(.DIV(DIV)) u_pre (
        .clk    (clk),
        .rst    (rst),
        .tick_i (slow_tick_i),
        .run_i  (run),
        .clr_i  (load),
        .step_o (step)
    );

    kwd_count #(.W(CNT_W)) u_cnt (
        .clk         (clk),
        .rst         (rst),
        .en_i        (en),
        .step_i      (step),
        .load_i      (load),
        .load_val_i  (load_val),
        .cnt_o       (cnt),
        .underflow_o (underflow)
    );

    kwd_regs u_regs (
        .clk         (clk),
        .rst         (rst),
        .wr_i        (bus_wr_i),
        .rd_i        (bus_rd_i),
        .addr_i      (bus_addr_i),
        .wdata_i     (bus_wdata_i),
        .cnt_i       (cnt),
        .underflow_i (underflow),
        .idle_i      (idle_i),
        .dbg_i       (dbg_halt_i),
        .rdata_o     (bus_rdata_o),
        .en_o        (en),
        .run_o       (run),
        .load_o      (load),
        .load_val_o  (load_val),
        .irq_o       (irq_o),
        .cpu_rst_o   (cpu_rst_o),
        .sys_rst_o   (sys_rst_o)
    );

    AST_SYS_IMPLIES_CPU: assert property (@(posedge clk) disable iff (rst)
        sys_rst_o |-> cpu_rst_o); // R7

    AST_RST_PULSE: assert property (@(posedge clk) disable iff (rst)
        (cpu_rst_o && !underflow) |=> !cpu_rst_o); // R7

endmodule

// File: tb/keyed_wdog_tb.sv
module keyed_wdog_tb;

    localparam int DIV = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        slow_tick = 1'b0;
    logic        idle = 1'b0;
    logic        dbg = 1'b0;
    logic        wr = 1'b0;
    logic        rd = 1'b0;
    logic [1:0]  addr = 2'd0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq, cpu_rst, sys_rst;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #4 clk = ~clk;

    keyed_wdog #(.DIV(DIV)) u_dut (
        .clk         (clk),
        .rst         (rst),
        .slow_tick_i (slow_tick),
        .idle_i      (idle),
        .dbg_halt_i  (dbg),
        .bus_wr_i    (wr),
        .bus_rd_i    (rd),
        .bus_addr_i  (addr),
        .bus_wdata_i (wdata),
        .bus_rdata_o (rdata),
        .irq_o       (irq),
        .cpu_rst_o   (cpu_rst),
        .sys_rst_o   (sys_rst)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; idle = 1'b0; dbg = 1'b0; slow_tick = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            slow_tick = 1'b1;
            @(negedge clk);
        end
        slow_tick = 1'b0;
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [31:0] d, input logic tk);
        wr = 1'b1; addr = a; wdata = d; slow_tick = tk;
        @(negedge clk);
        wr = 1'b0; wdata = '0; slow_tick = 1'b0;
    endtask

    task automatic bus_read(input logic [1:0] a, input logic tk, output logic [31:0] d);
        rd = 1'b1; addr = a; slow_tick = tk;
        #1 d = rdata;
        @(negedge clk);
        rd = 1'b0; slow_tick = 1'b0;
    endtask

    task automatic t_reset_state();
        logic [31:0] d;
        do_reset();
        bus_read(2'd1, 1'b0, d);
        chk("R2 default config", d, 32'h02FF_FFFF);
        bus_read(2'd2, 1'b0, d);
        chk("R1 reset count", d, 32'h0FFF_0000);
        chk("R8 irq idle", {31'b0, irq}, 32'h0);
        chk("R7 resets idle", {30'b0, cpu_rst, sys_rst}, 32'h0);
    endtask

    task automatic t_count_irq();
        logic [31:0] d;
        do_reset();
        bus_write(2'd1, 32'h0100_5005, 1'b0);
        ticks(4);
        bus_read(2'd2, 1'b0, d);
        chk("R1 one step per DIV ticks", d, 32'h0004_0000);
        ticks(16);
        ticks(3);
        chk("R1 no fault before last tick", {31'b0, irq}, 32'h0);
        ticks(1);
        chk("R8 irq on underflow", {31'b0, irq}, 32'h1);
        chk("R7 no reset when disabled in config", {30'b0, cpu_rst, sys_rst}, 32'h0);
        bus_read(2'd2, 1'b0, d);
        chk("R1 underflow flag and reload", d, 32'h0005_0001);
        chk("R8 irq cleared by read", {31'b0, irq}, 32'h0);
        bus_write(2'd1, 32'h0000_0009, 1'b0);
        bus_read(2'd1, 1'b0, d);
        chk("R2 second config write ignored", d, 32'h0100_5005);
    endtask

    task automatic t_sys_reset();
        logic [31:0] d;
        do_reset();
        bus_write(2'd1, 32'h0200_2002, 1'b0);
        ticks(11);
        chk("R7 no reset early", {30'b0, cpu_rst, sys_rst}, 32'h0);
        ticks(1);
        chk("R7 cpu and sys reset on fault", {30'b0, cpu_rst, sys_rst}, 32'h3);
        chk("R8 irq masked", {31'b0, irq}, 32'h0);
        @(negedge clk);
        chk("R7 reset is a pulse", {30'b0, cpu_rst, sys_rst}, 32'h0);
        bus_read(2'd2, 1'b0, d);
        chk("R8 flag set without irq enable", d, 32'h0002_0001);
    endtask

    task automatic t_proc_only();
        do_reset();
        bus_write(2'd1, 32'h0600_2002, 1'b0);
        ticks(12);
        chk("R7 processor-only reset", {30'b0, cpu_rst, sys_rst}, 32'h2);
    endtask

    task automatic t_restart();
        logic [31:0] d;
        do_reset();
        bus_write(2'd1, 32'h0100_A00A, 1'b0);
        ticks(8);
        bus_write(2'd0, 32'h5A00_0001, 1'b0);
        bus_read(2'd2, 1'b0, d);
        chk("R5 wrong key ignored", d, 32'h0008_0000);
        bus_write(2'd0, 32'hA500_0001, 1'b0);
        bus_read(2'd2, 1'b0, d);
        chk("R4 keyed restart reloads", d, 32'h000A_0000);
        ticks(40);
        ticks(3);
        bus_write(2'd0, 32'hA500_0001, 1'b1);
        chk("R4 restart beats underflow irq", {31'b0, irq}, 32'h0);
        bus_read(2'd2, 1'b0, d);
        chk("R4 restart beats underflow status", d, 32'h000A_0000);
    endtask

    task automatic t_early_error();
        logic [31:0] d;
        do_reset();
        bus_write(2'd1, 32'h0100_600A, 1'b0);
        bus_write(2'd0, 32'hA500_0001, 1'b0);
        chk("R6 early restart irq", {31'b0, irq}, 32'h1);
        bus_read(2'd2, 1'b0, d);
        chk("R6 error flag and reload", d, 32'h000A_0002);
        ticks(16);
        bus_write(2'd0, 32'hA500_0001, 1'b0);
        bus_read(2'd2, 1'b0, d);
        chk("R6 restart at delta is fine", d, 32'h000A_0000);
    endtask

    task automatic t_read_collision();
        logic [31:0] d;
        do_reset();
        bus_write(2'd1, 32'h0100_1001, 1'b0);
        ticks(8);
        ticks(7);
        bus_read(2'd2, 1'b1, d);
        chk("R8 read sees old flag", d, 32'h0000_0001);
        chk("R8 irq kept on collision", {31'b0, irq}, 32'h1);
        bus_read(2'd2, 1'b0, d);
        chk("R8 new fault survives read", d, 32'h0001_0001);
        bus_read(2'd2, 1'b0, d);
        chk("R8 flag cleared later", d, 32'h0001_0000);
    endtask

    task automatic t_freeze();
        logic [31:0] d;
        do_reset();
        bus_write(2'd1, 32'h1000_8008, 1'b0);
        idle = 1'b1;
        ticks(8);
        idle = 1'b0;
        bus_read(2'd2, 1'b0, d);
        chk("R9 idle hold freezes", d, 32'h0008_0000);
        dbg = 1'b1;
        ticks(4);
        dbg = 1'b0;
        bus_read(2'd2, 1'b0, d);
        chk("R9 debug input ignored without hold", d, 32'h0007_0000);
    endtask

    task automatic t_disable();
        logic [31:0] d;
        int seen = 0;
        do_reset();
        bus_write(2'd1, 32'h0A00_1003, 1'b0);
        for (int i = 0; i < 40; i++) begin
            ticks(1);
            if (cpu_rst || sys_rst) seen++;
        end
        chk("R3 no fault while disabled", seen, 0);
        bus_write(2'd0, 32'hA500_0001, 1'b0);
        bus_read(2'd2, 1'b0, d);
        chk("R3 frozen and restart ignored", d, 32'h0003_0000);
        bus_write(2'd1, 32'h0100_3003, 1'b0);
        bus_read(2'd1, 1'b0, d);
        chk("R3 disable is permanent", d, 32'h0A00_1003);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        t_reset_state();
        t_count_irq();
        t_sys_reset();
        t_proc_only();
        t_restart();
        t_early_error();
        t_read_collision();
        t_freeze();
        t_disable();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule